// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block carries out the stack-touching and flow-changing instructions of a small 8-bit processor core. It owns the 16-bit stack pointer and talks to a byte-wide data memory, one byte per clock. Each command arrives as a one-cycle `start` pulse. With it come an operation code, a condition code, the four status flags, the return address (`pc_in`), a branch target, a register-pair value and a restart number. The block decides whether a conditional operation is taken. It then moves the required bytes to or from the stack and ends with a one-cycle `done` pulse.

On `done` the block presents the new program counter with a load strobe when control moves, and the popped word when it read one. It also shows the instruction's cost in T-states, which differs between the taken and not-taken outcomes. Instruction fetch, decode and the arithmetic unit are outside this block. The caller supplies the return address and reacts to `pc_load`.

Top module: `stk_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the stack pointer becomes `SP_RESET` (default 0000h) and `done`, `busy`, `pc_load`, `mem_we` and `mem_re` are low after that edge.
- R2: Operation codes are CALL=0, conditional CALL=1, RET=2, conditional RET=3, RST=4, PUSH=5, POP=6 and conditional jump=7. For codes 1, 3 and 7, bits [2:1] of `cond` pick the flag (00 zero, 01 carry, 10 parity, 11 sign) and bit 0 gives the value that flag must have for the operation to be taken. So NZ=000, Z=001, NC=010, C=011, PO=100, PE=101, P=110 and M=111. All other codes are always taken.
- R3: A taken CALL or RST, and every PUSH, writes the high byte of the stored word to SP-1 and then the low byte to SP-2, leaving SP at SP-2. The stored word is `pc_in` for CALL and RST and `pair_in` for PUSH.
- R4: A taken RET, and every POP, reads the low byte from SP and then the high byte from SP+1, leaving SP at SP+2. On `done`, `pair_out` holds the assembled word.
- R5: RST n loads the program counter with 8×n, where n is `rst_num`, giving 0000h to 0038h.
- R6: On `done` of a taken CALL, RST, RET or conditional jump, `pc_load` is high. `pc_out` then holds the target (CALL and jump), the restart vector (RST) or the popped word (RET). PUSH, POP and not-taken operations leave `pc_load` low.
- R7: A not-taken operation and a conditional jump make no memory access and leave SP unchanged.
- R8: `done` is high for exactly one cycle. It follows the start edge by three clock edges when memory is accessed and by one edge otherwise. `busy` is high from the edge after `start` through the `done` cycle.
- R9: On `done`, `tstates` shows the cost: CALL 18, conditional CALL 18 if taken and 9 if not, RET 10, conditional RET 12 if taken and 6 if not, RST 12, PUSH 12, POP 10, conditional jump 10 if taken and 7 if not.
- R10: The stack pointer wraps modulo 2^16 in both directions.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation code |
| cond | input | 3 | Condition code for conditional operations |
| flag_z | input | 1 | Zero flag |
| flag_cy | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag |
| flag_s | input | 1 | Sign flag |
| pc_in | input | 16 | Return address to push on a call |
| target | input | 16 | Branch or call target |
| pair_in | input | 16 | Register-pair value to push |
| rst_num | input | 3 | Restart number n |
| mem_addr | output | 16 | Data memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read byte, valid in the same cycle as the address |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Program counter load strobe |
| pair_out | output | 16 | Popped word |
| sp_out | output | 16 | Current stack pointer |
| done | output | 1 | Operation complete |
| busy | output | 1 | Operation in progress |
| tstates | output | 5 | Cost of the operation in T-states |

## Verification
The block's results arrive at one of two fixed times. For an operation that reaches memory, `done`, `pc_out`, `pair_out`, `tstates` and the final SP are due three clock edges after the edge that sampled `start`. Everything else delivers them one edge after that edge. The bench samples the outputs on falling edges and counts them from the start edge. The latency check fails if `done` shows up on any other falling edge. Memory contents and the bench's counts of write and read strobes are checked in that same `done` cycle, and `done` is checked low again on the next falling edge.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_CALL  = 3'd0,
        OP_CALLC = 3'd1,
        OP_RET   = 3'd2,
        OP_RETC  = 3'd3,
        OP_RST   = 3'd4,
        OP_PUSH  = 3'd5,
        OP_POP   = 3'd6,
        OP_JMPC  = 3'd7
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BYTE0 = 2'd1,
        ST_BYTE1 = 2'd2,
        ST_DONE  = 2'd3
    } stk_state_e;

    typedef struct packed {
        logic s;
        logic p;
        logic cy;
        logic z;
    } stk_flags_t;

    localparam int TS_W = 5;

    // cond[2:1] picks the flag, cond[0] is the value needed (R2)
    function automatic logic cond_met(logic [2:0] cc, stk_flags_t f);
        logic sel;
        case (cc[2:1])
            2'd0:    sel = f.z;
            2'd1:    sel = f.cy;
            2'd2:    sel = f.p;
            default: sel = f.s;
        endcase
        return sel == cc[0];
    endfunction

    function automatic logic is_conditional(stk_op_e o);
        return (o == OP_CALLC) || (o == OP_RETC) || (o == OP_JMPC);
    endfunction

    function automatic logic is_writer(stk_op_e o);
        return (o == OP_CALL) || (o == OP_CALLC) || (o == OP_RST) || (o == OP_PUSH);
    endfunction

    function automatic logic is_reader(stk_op_e o);
        return (o == OP_RET) || (o == OP_RETC) || (o == OP_POP);
    endfunction

    function automatic logic moves_pc(stk_op_e o);
        return (o != OP_PUSH) && (o != OP_POP);
    endfunction

    // T-state cost per operation and outcome (R9)
    function automatic logic [TS_W-1:0] op_cost(stk_op_e o, logic taken);
        case (o)
            OP_CALL:  return 5'd18;
            OP_CALLC: return taken ? 5'd18 : 5'd9;
            OP_RET:   return 5'd10;
            OP_RETC:  return taken ? 5'd12 : 5'd6;
            OP_RST:   return 5'd12;
            OP_PUSH:  return 5'd12;
            OP_POP:   return 5'd10;
            default:  return taken ? 5'd10 : 5'd7;
        endcase
    endfunction

endpackage

// File: rtl/stk_cond_cost.sv
module stk_cond_cost
    import stk_pkg::*;
(
    input  stk_op_e          op,
    input  logic [2:0]       cc,
    input  stk_flags_t       flags,
    output logic             taken,
    output logic [TS_W-1:0]  cost
);
    always_comb begin
        taken = is_conditional(op) ? cond_met(cc, flags) : 1'b1;
        cost  = op_cost(op, taken);
    end
endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
    parameter int             AW     = 16,
    parameter logic [AW-1:0]  RST_VAL = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dec,
    input  logic           inc,
    output logic [AW-1:0]  sp
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Natural AW-bit arithmetic gives the modulo wrap (R10)
    always_ff @(posedge clk) begin
        if (rst)      sp <= RST_VAL;
        else if (dec) sp <= sp - ONE;
        else if (inc) sp <= sp + ONE;
    end
endmodule

// File: rtl/stk_word_buf.sv
module stk_word_buf #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [2*DW-1:0] load_val,
    input  logic            cap,
    input  logic            hi_sel,
    input  logic [DW-1:0]   rbyte,
    output logic [DW-1:0]   wbyte,
    output logic [2*DW-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (load) begin
            word <= load_val;
        end else if (cap) begin
            if (hi_sel) word[2*DW-1:DW] <= rbyte;
            else        word[DW-1:0]    <= rbyte;
        end
    end

    assign wbyte = hi_sel ? word[2*DW-1:DW] : word[DW-1:0];
endmodule

// File: rtl/stk_unit.sv
module stk_unit
    import stk_pkg::*;
#(
    parameter int             DW       = 8,
    parameter int             AW       = 2 * DW,
    parameter logic [AW-1:0]  SP_RESET = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [2:0]       cond,
    input  logic             flag_z,
    input  logic             flag_cy,
    input  logic             flag_p,
    input  logic             flag_s,
    input  logic [AW-1:0]    pc_in,
    input  logic [AW-1:0]    target,
    input  logic [AW-1:0]    pair_in,
    input  logic [2:0]       rst_num,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_re,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    pc_out,
    output logic             pc_load,
    output logic [AW-1:0]    pair_out,
    output logic [AW-1:0]    sp_out,
    output logic             done,
    output logic             busy,
    output logic [TS_W-1:0]  tstates
);
    localparam logic [AW-1:0] ONE = AW'(1);

    stk_op_e          op_in;
    stk_flags_t       flags_in;
    logic             taken_in;
    logic [TS_W-1:0]  cost_in;

    stk_state_e       state;
    stk_op_e          op_q;
    logic             taken_q;
    logic [AW-1:0]    dest_q;
    logic [TS_W-1:0]  cost_q;

    logic             accept;
    logic             in_xfer;
    logic             hi_sel;
    logic [AW-1:0]    word;
    logic [AW-1:0]    push_val;
    logic [AW-1:0]    vector;

    assign op_in    = stk_op_e'(op);
    assign flags_in = '{s: flag_s, p: flag_p, cy: flag_cy, z: flag_z};

    stk_cond_cost u_cond (
        .op    (op_in),
        .cc    (cond),
        .flags (flags_in),
        .taken (taken_in),
        .cost  (cost_in)
    );

    assign accept   = start && (state == ST_IDLE);
    assign vector   = AW'({rst_num, 3'b000});
    assign push_val = (op_in == OP_PUSH) ? pair_in : pc_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= OP_CALL;
            taken_q <= 1'b0;
            dest_q  <= '0;
            cost_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    op_q    <= op_in;
                    taken_q <= taken_in;
                    cost_q  <= cost_in;
                    dest_q  <= (op_in == OP_RST) ? vector : target;
                    state   <= (taken_in && (is_writer(op_in) || is_reader(op_in)))
                               ? ST_BYTE0 : ST_DONE;
                end
                ST_BYTE0: state <= ST_BYTE1;
                ST_BYTE1: state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign in_xfer = (state == ST_BYTE0) || (state == ST_BYTE1);
    assign mem_we  = in_xfer && is_writer(op_q);
    assign mem_re  = in_xfer && is_reader(op_q);
    // writes go high byte first, reads low byte first
    assign hi_sel  = is_writer(op_q) ? (state == ST_BYTE0) : (state == ST_BYTE1);
    assign mem_addr = mem_we ? (sp_out - ONE) : sp_out;

    stk_sp_reg #(.AW(AW), .RST_VAL(SP_RESET)) u_sp (
        .clk (clk),
        .rst (rst),
        .dec (mem_we),
        .inc (mem_re),
        .sp  (sp_out)
    );

    stk_word_buf #(.DW(DW)) u_word (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (push_val),
        .cap      (mem_re),
        .hi_sel   (hi_sel),
        .rbyte    (mem_rdata),
        .wbyte    (mem_wdata),
        .word     (word)
    );

    assign done     = (state == ST_DONE);
    assign busy     = (state != ST_IDLE);
    assign pc_load  = done && taken_q && moves_pc(op_q);
    assign pc_out   = is_reader(op_q) ? word : dest_q;
    assign pair_out = word;
    assign tstates  = cost_q;

endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input logic           clk,
    input logic           rst,
    input logic           done,
    input logic           busy,
    input logic           pc_load,
    input logic           mem_we,
    input logic           mem_re,
    input logic [AW-1:0]  sp_out
);
    localparam logic [AW-1:0] ONE = AW'(1);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_one_direction_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    assert_push_step_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_out == $past(sp_out) - ONE));

    assert_pop_step_R4: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (sp_out == $past(sp_out) + ONE));

    assert_load_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> done);

    assert_sp_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!mem_we && !mem_re) |=> $stable(sp_out));

    assert_access_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

endmodule

bind stk_unit stk_unit_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_stk_unit.sv
module tb_stk_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [2:0]  cond = '0;
    logic        flag_z = 1'b0, flag_cy = 1'b0, flag_p = 1'b0, flag_s = 1'b0;
    logic [15:0] pc_in = '0, target = '0, pair_in = '0;
    logic [2:0]  rst_num = '0;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] pc_out, pair_out, sp_out;
    logic        pc_load, done, busy;
    logic [4:0]  tstates;

    logic [7:0]  mem [0:255];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] model_sp = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_unit dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .cond(cond),
        .flag_z(flag_z), .flag_cy(flag_cy), .flag_p(flag_p), .flag_s(flag_s),
        .pc_in(pc_in), .target(target), .pair_in(pair_in), .rst_num(rst_num),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .pc_out(pc_out), .pc_load(pc_load), .pair_out(pair_out),
        .sp_out(sp_out), .done(done), .busy(busy), .tstates(tstates)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Apply one operation and check every result in the done cycle
    task automatic run_op(input logic [2:0] o, input logic [2:0] cc, input logic [3:0] fl,
                          input logic [15:0] pcv, input logic [15:0] tgt, input logic [15:0] pv);
        logic        cnd, taken, wr, rd, mv;
        logic [15:0] sp0, popv, exp_pc, stored;
        logic [4:0]  cost;
        int          lat, wr0, rd0;
        // R2: flags {s,p,cy,z}, cond[2:1] picks the flag, cond[0] the value needed
        cnd   = (o == 3'd1) || (o == 3'd3) || (o == 3'd7);
        taken = cnd ? (fl[cc[2:1]] == cc[0]) : 1'b1;
        wr    = taken && ((o == 3'd0) || (o == 3'd1) || (o == 3'd4) || (o == 3'd5));
        rd    = taken && ((o == 3'd2) || (o == 3'd3) || (o == 3'd6));
        mv    = taken && (o != 3'd5) && (o != 3'd6);
        case (o)
            3'd0: cost = 5'd18;
            3'd1: cost = taken ? 5'd18 : 5'd9;
            3'd2: cost = 5'd10;
            3'd3: cost = taken ? 5'd12 : 5'd6;
            3'd4: cost = 5'd12;
            3'd5: cost = 5'd12;
            3'd6: cost = 5'd10;
            default: cost = taken ? 5'd10 : 5'd7;
        endcase
        sp0    = model_sp;
        popv   = pv ^ 16'h5A3C ^ {8'h00, pcv[7:0]};
        stored = (o == 3'd5) ? pv : pcv;
        case (o)
            3'd2, 3'd3: exp_pc = popv;
            3'd4:       exp_pc = {10'd0, cc, 3'b000};
            default:    exp_pc = tgt;
        endcase
        mem[sp0[7:0]]              = popv[7:0];
        mem[8'(sp0[7:0] + 8'd1)]   = popv[15:8];
        wr0 = wr_cnt;
        rd0 = rd_cnt;
        op = o; cond = cc;
        {flag_s, flag_p, flag_cy, flag_z} = fl;
        pc_in = pcv; target = tgt; pair_in = pv; rst_num = cc;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency", 32'(lat), (wr || rd) ? 32'd3 : 32'd1);
        chk("R9 tstates", 32'(tstates), 32'(cost));
        chk("R6 pc_load", 32'(pc_load), 32'(mv));
        if (mv) chk(o == 3'd4 ? "R5 vector" : "R6 pc_out", 32'(pc_out), 32'(exp_pc));
        if (wr) begin
            chk("R3 sp", 32'(sp_out), 32'(16'(sp0 - 16'd2)));
            chk("R3 high byte", 32'(mem[8'(sp0[7:0] - 8'd1)]), 32'(stored[15:8]));
            chk("R3 low byte", 32'(mem[8'(sp0[7:0] - 8'd2)]), 32'(stored[7:0]));
            chk("R3 writes", 32'(wr_cnt - wr0), 32'd2);
            model_sp = sp0 - 16'd2;
        end else if (rd) begin
            chk("R4 sp", 32'(sp_out), 32'(16'(sp0 + 16'd2)));
            chk("R4 pair_out", 32'(pair_out), 32'(popv));
            chk("R4 reads", 32'(rd_cnt - rd0), 32'd2);
            model_sp = sp0 + 16'd2;
        end else begin
            chk("R7 sp unchanged", 32'(sp_out), 32'(sp0));
            chk("R7 no access", 32'((wr_cnt - wr0) + (rd_cnt - rd0)), 32'd0);
        end
        @(negedge clk);
        chk("R8 done single", 32'(done), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R8 watchdog: actual hung expected done");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 sp", 32'(sp_out), 32'h0000);
        chk("R1 strobes", 32'({done, busy, pc_load, mem_we, mem_re}), 32'd0);

        // R10: push from 0000h wraps to FFFEh, pop brings it back
        run_op(3'd5, 3'd0, 4'd0, 16'h0000, 16'h0000, 16'hBEEF);
        chk("R10 wrap down", 32'(sp_out), 32'hFFFE);
        run_op(3'd6, 3'd0, 4'd0, 16'h0000, 16'h0000, 16'h1234);
        chk("R10 wrap up", 32'(sp_out), 32'h0000);
        run_op(3'd6, 3'd0, 4'd0, 16'h0000, 16'h0000, 16'h4321);
        chk("R10 wrap top", 32'(sp_out), 32'h0002);

        // R11: start held high through a push, alternate op offered meanwhile
        begin
            int wr0, rd0;
            logic [15:0] s0;
            wr0 = wr_cnt; rd0 = rd_cnt; s0 = model_sp;
            op = 3'd5; pair_in = 16'hC0DE; start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            op = 3'd6;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
            chk("R11 done", 32'(done), 32'd1);
            chk("R11 writes", 32'(wr_cnt - wr0), 32'd2);
            chk("R11 reads", 32'(rd_cnt - rd0), 32'd0);
            chk("R11 sp", 32'(sp_out), 32'(16'(s0 - 16'd2)));
            model_sp = s0 - 16'd2;
            @(negedge clk);
            chk("R11 idle", 32'(busy), 32'd0);
        end

        // Sweep: every op, every condition code, every flag pattern
        for (int o = 0; o < 8; o++) begin
            for (int c = 0; c < 8; c++) begin
                for (int f = 0; f < 16; f++) begin
                    run_op(3'(o), 3'(c), 4'(f),
                           16'(16'h1000 + o * 16'h0111 + c * 16'h0020 + f),
                           16'(16'h8000 ^ (o << 8) ^ (c << 4) ^ f),
                           16'(16'hA500 + (f << 8) + (c << 3) + o));
                end
            end
        end
        summary();
    end
endmodule